// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block sits in front of a single shared word memory and serves several requesters that need atomic read-modify-write without a bus lock. A requester reads a word with a linked load, which both returns the word and marks a reservation for that requester on that address. Later it issues a conditional store to the same address. The store takes effect only if nothing has written that address since the linked load. The requester gets 1 when the store lands and 0 when it was refused, and on 0 it retries its read-modify-write loop.

Ordinary loads and stores go through the same path. A round-robin arbiter picks one request per cycle. The granted request reaches the memory and updates the reservation table, so reservation state changes in one place at a time. Every write that completes, from any requester, clears the reservations that name the written address. Each requester holds one reservation at most.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is pending and no reservation is held, so a conditional store issued first after reset fails. The arbiter starts searching at requester 0.
- R2: Each cycle, `req_grant` is driven combinationally in the same cycle. It selects at most one requester with `req_valid` set, searching upward with wrap-around from a pointer. After each grant the pointer moves to the index after the granted one.
- R3: The word address of a request is `base + offset`, taken modulo 2^AW.
- R4: Operation codes are 2'b00 load, 2'b01 store, 2'b10 linked load and 2'b11 conditional store. One cycle after a grant, `rsp_valid` pulses for the granted requester. `rsp_rdata` then carries the word held at the address before this request's own write. `rsp_success` is 1 for load, store and linked load.
- R5: A linked load records a reservation for its requester on its address. This replaces any earlier reservation of that requester.
- R6: A conditional store whose requester holds a valid reservation on the same address writes its data and answers success 1.
- R7: A conditional store without a valid reservation, or with one on a different address, leaves memory unchanged and answers success 0.
- R8: A conditional store clears its requester's own reservation, whether it succeeds or fails.
- R9: Every completed write clears the reservation of every requester that holds that address. A completed write is a store or a successful conditional store. Reservations on other addresses survive.
- R10: A request that is not granted has no effect on memory or on reservations, and receives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Request present, one bit per requester |
| req_op | input | 2*N | Operation code per requester (2 bits each) |
| req_base | input | N*AW | Base word address per requester |
| req_offset | input | N*AW | Immediate offset per requester |
| req_wdata | input | N*DW | Store data per requester |
| req_grant | output | N | One-hot grant, same cycle as the request |
| rsp_valid | output | N | Response strobe, one cycle after the grant |
| rsp_rdata | output | N*DW | Word read at the request address, per requester |
| rsp_success | output | N | Operation outcome, 0 only for a refused conditional store |

## Verification
The grant is combinational, so it is checked 1 ns after the inputs change, in the same cycle. The response passes through one register stage, so it is checked at the falling edge that follows the next rising edge. A write or a reservation change made at one rising edge first affects a request granted at the next edge. The reference model therefore applies each granted request in request order, and the following cycle's expectations come from the updated state. Requests that are not granted are left out of the model, so any trace they leave on the design shows up as a later mismatch.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_rr_arb.sv
// Round-robin arbiter: one grant per cycle, search starts at ptr_q.
module llsc_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          grant_any
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int cand;
    grant     = '0;
    grant_idx = '0;
    grant_any = 1'b0;
    cand      = 0;
    for (int k = 0; k < N; k++) begin
      cand = int'(ptr_q) + k;
      if (cand >= N) cand = cand - N;
      if (!grant_any && req[cand]) begin
        grant_any   = 1'b1;
        grant[cand] = 1'b1;
        grant_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (grant_any) begin
      if (grant_idx == IW'(N - 1)) ptr_q <= '0;
      else                         ptr_q <= grant_idx + 1'b1;
    end
  end
endmodule

// File: rtl/llsc_resv_table.sv
// One reservation (valid + address) per requester.
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [IW-1:0] op_idx,
  input  llsc_op_e      op_code,
  input  logic [AW-1:0] op_addr,
  input  logic          wr_commit,
  output logic [N-1:0]  resv_valid,
  output logic          hit
);
  logic [AW-1:0] resv_addr [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        resv_valid[i] <= 1'b0;
        resv_addr[i]  <= '0;
      end else begin
        // Any completed write to the held address kills the reservation.
        if (wr_commit && resv_valid[i] && (resv_addr[i] == op_addr))
          resv_valid[i] <= 1'b0;
        if (op_valid && (op_idx == IW'(i))) begin
          if (op_code == OP_LINK) begin
            resv_valid[i] <= 1'b1;
            resv_addr[i]  <= op_addr;
          end else if (op_code == OP_COND) begin
            resv_valid[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign hit = resv_valid[op_idx] && (resv_addr[op_idx] == op_addr);
endmodule

// File: rtl/llsc_mem.sv
// Single-port word memory, read-first, registered read for block RAM.
module llsc_mem #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_valid,
  input  logic [2*N-1:0]  req_op,
  input  logic [N*AW-1:0] req_base,
  input  logic [N*AW-1:0] req_offset,
  input  logic [N*DW-1:0] req_wdata,
  output logic [N-1:0]    req_grant,
  output logic [N-1:0]    rsp_valid,
  output logic [N*DW-1:0] rsp_rdata,
  output logic [N-1:0]    rsp_success
);
  llsc_op_e      op_arr   [N];
  logic [AW-1:0] addr_arr [N];
  logic [DW-1:0] wd_arr   [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign op_arr[i]   = llsc_op_e'(req_op[2*i +: 2]);
    assign addr_arr[i] = req_base[AW*i +: AW] + req_offset[AW*i +: AW];
    assign wd_arr[i]   = req_wdata[DW*i +: DW];
  end

  logic [IW-1:0] grant_idx;
  logic          grant_any;

  llsc_rr_arb #(.N(N)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (req_valid),
    .grant     (req_grant),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  llsc_op_e      sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic          hit;
  logic          wr_commit;
  logic          succ;
  logic [N-1:0]  resv_valid;

  assign sel_op    = op_arr[grant_idx];
  assign sel_addr  = addr_arr[grant_idx];
  assign sel_wdata = wd_arr[grant_idx];
  assign wr_commit = grant_any && ((sel_op == OP_STORE) || ((sel_op == OP_COND) && hit));
  assign succ      = (sel_op == OP_COND) ? hit : 1'b1;

  llsc_resv_table #(.N(N), .AW(AW)) u_resv (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (grant_any),
    .op_idx     (grant_idx),
    .op_code    (sel_op),
    .op_addr    (sel_addr),
    .wr_commit  (wr_commit),
    .resv_valid (resv_valid),
    .hit        (hit)
  );

  logic [DW-1:0] mem_rdata;

  llsc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (wr_commit),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  logic [N-1:0] rsp_valid_q;
  logic         succ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= '0;
      succ_q      <= 1'b0;
    end else begin
      rsp_valid_q <= req_grant;
      if (grant_any) succ_q <= succ;
    end
  end

  assign rsp_valid = rsp_valid_q;
  for (genvar i = 0; i < N; i++) begin : g_rsp
    assign rsp_rdata[DW*i +: DW] = mem_rdata;
    assign rsp_success[i]        = succ_q;
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req_valid,
  input logic [N-1:0]  req_grant,
  input logic [N-1:0]  rsp_valid,
  input logic [N-1:0]  rsp_success,
  input logic [N-1:0]  resv_valid,
  input logic          grant_any,
  input logic [IW-1:0] grant_idx,
  input llsc_op_e      sel_op
);
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_grant));

  a_r10_grant_needs_request: assert property (@(posedge clk) disable iff (rst)
    (req_grant & ~req_valid) == '0);

  a_r4_rsp_follows_grant: assert property (@(posedge clk) disable iff (rst)
    grant_any |=> rsp_valid == $past(req_grant));

  a_r10_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !grant_any |=> rsp_valid == '0);

  a_r5_link_sets_resv: assert property (@(posedge clk) disable iff (rst)
    (grant_any && sel_op == OP_LINK) |=> resv_valid[$past(grant_idx)]);

  a_r8_cond_clears_own: assert property (@(posedge clk) disable iff (rst)
    (grant_any && sel_op == OP_COND) |=> !resv_valid[$past(grant_idx)]);

  a_r7_cond_without_resv_fails: assert property (@(posedge clk) disable iff (rst)
    (grant_any && sel_op == OP_COND && !resv_valid[grant_idx])
      |=> !rsp_success[$past(grant_idx)]);
endmodule

bind llsc_monitor llsc_monitor_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_grant   (req_grant),
  .rsp_valid   (rsp_valid),
  .rsp_success (rsp_success),
  .resv_valid  (resv_valid),
  .grant_any   (grant_any),
  .grant_idx   (grant_idx),
  .sel_op      (sel_op)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [N*AW-1:0] req_base = '0;
  logic [N*AW-1:0] req_offset = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    req_grant;
  logic [N-1:0]    rsp_valid;
  logic [N*DW-1:0] rsp_rdata;
  logic [N-1:0]    rsp_success;

  always #2 clk = ~clk;

  llsc_monitor #(.N(N), .AW(AW), .DW(DW)) u_llsc_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_success(rsp_success)
  );

  int compared = 0;
  int mismatched = 0;

  // pending stimulus
  logic          b_v    [N];
  logic [1:0]    b_op   [N];
  logic [AW-1:0] b_base [N];
  logic [AW-1:0] b_off  [N];
  logic [DW-1:0] b_wd   [N];

  // reference model state
  logic [DW-1:0] m_mem [1 << AW];
  logic          m_rv  [N];
  logic [AW-1:0] m_ra  [N];
  int            m_ptr = 0;
  logic [N-1:0]  e_rv = '0;
  logic [DW-1:0] e_rd  [N];
  logic          e_ok  [N];
  string         e_tag [N];
  string         rv_tag = "R1";

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_req(input int r, input logic [1:0] op, input logic [AW-1:0] base,
                         input logic [AW-1:0] off, input logic [DW-1:0] wd);
    b_v[r] = 1'b1; b_op[r] = op; b_base[r] = base; b_off[r] = off; b_wd[r] = wd;
  endtask

  task automatic cycle();
    int g;
    logic [AW-1:0] a;
    logic [N-1:0] eg;
    logic h;
    @(negedge clk);
    check(rv_tag, "rsp_valid", DW'(rsp_valid), DW'(e_rv));
    rv_tag = "R10";
    for (int i = 0; i < N; i++) begin
      if (e_rv[i]) begin
        check(e_tag[i], "rsp_rdata", rsp_rdata[DW*i +: DW], e_rd[i]);
        check(e_tag[i], "rsp_success", DW'(rsp_success[i]), DW'(e_ok[i]));
      end
    end
    for (int i = 0; i < N; i++) begin
      req_valid[i]            = b_v[i];
      req_op[2*i +: 2]        = b_op[i];
      req_base[AW*i +: AW]    = b_base[i];
      req_offset[AW*i +: AW]  = b_off[i];
      req_wdata[DW*i +: DW]   = b_wd[i];
    end
    #1;
    g = -1;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (m_ptr + k) % N;
      if (g < 0 && b_v[c]) g = c;
    end
    eg = '0;
    if (g >= 0) eg[g] = 1'b1;
    check("R2", "req_grant", DW'(req_grant), DW'(eg));
    e_rv = eg;
    if (g >= 0) begin
      m_ptr = (g + 1) % N;
      a = b_base[g] + b_off[g];            // R3: modulo 2^AW sum
      e_rd[g] = m_mem[a];
      e_ok[g] = 1'b1;
      case (b_op[g])
        LD: e_tag[g] = "R4";
        ST: begin
          e_tag[g] = "R4/R9";
          m_mem[a] = b_wd[g];
          for (int j = 0; j < N; j++) if (m_rv[j] && m_ra[j] == a) m_rv[j] = 1'b0;
        end
        LL: begin
          e_tag[g] = "R5";
          m_rv[g] = 1'b1; m_ra[g] = a;
        end
        default: begin
          h = m_rv[g] && (m_ra[g] == a);
          m_rv[g] = 1'b0;                  // R8
          e_ok[g] = h;
          e_tag[g] = h ? "R6" : "R7";
          if (h) begin
            m_mem[a] = b_wd[g];
            for (int j = 0; j < N; j++) if (m_rv[j] && m_ra[j] == a) m_rv[j] = 1'b0;
          end
        end
      endcase
    end
    for (int i = 0; i < N; i++) b_v[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
    for (int i = 0; i < N; i++) begin
      m_rv[i] = 1'b0; m_ra[i] = '0; e_rd[i] = '0; e_ok[i] = 1'b0; e_tag[i] = "R4";
      b_v[i] = 1'b0; b_op[i] = '0; b_base[i] = '0; b_off[i] = '0; b_wd[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: idle after reset, then a conditional store with no reservation fails
    cycle();
    set_req(0, SC, 8'd5, 8'd0, 32'hAAAA_0001); cycle();
    // R9: store by another requester kills the reservation
    set_req(0, LL, 8'd5, 8'd0, '0); cycle();
    set_req(1, ST, 8'd5, 8'd0, 32'h0000_0011); cycle();
    set_req(0, SC, 8'd5, 8'd0, 32'h0000_0022); cycle();
    set_req(0, LD, 8'd5, 8'd0, '0); cycle();
    // R6 success, then R8: the second attempt has no reservation
    set_req(0, LL, 8'd6, 8'd0, '0); cycle();
    set_req(0, SC, 8'd6, 8'd0, 32'h0000_0033); cycle();
    set_req(0, SC, 8'd6, 8'd0, 32'h0000_0044); cycle();
    set_req(0, LD, 8'd6, 8'd0, '0); cycle();
    // R9: successful conditional store clears another requester's reservation
    set_req(1, LL, 8'd7, 8'd0, '0); cycle();
    set_req(2, LL, 8'd7, 8'd0, '0); cycle();
    set_req(1, SC, 8'd7, 8'd0, 32'h0000_0055); cycle();
    set_req(2, SC, 8'd7, 8'd0, 32'h0000_0066); cycle();
    // R5: a new linked load replaces the old reservation
    set_req(3, LL, 8'd8, 8'd0, '0); cycle();
    set_req(3, LL, 8'd9, 8'd0, '0); cycle();
    set_req(3, SC, 8'd8, 8'd0, 32'h0000_0088); cycle();
    set_req(3, LL, 8'd9, 8'd0, '0); cycle();
    set_req(3, SC, 8'd9, 8'd0, 32'h0000_0099); cycle();
    // R3: address wraps modulo 2^AW (250 + 10 = 4)
    set_req(2, ST, 8'd250, 8'd10, 32'h0000_0077); cycle();
    set_req(2, LD, 8'd0, 8'd4, '0); cycle();
    // R9: a write elsewhere leaves the reservation intact
    set_req(0, LL, 8'd3, 8'd0, '0); cycle();
    set_req(1, ST, 8'd2, 8'd0, 32'h0000_0123); cycle();
    set_req(0, SC, 8'd3, 8'd0, 32'h0000_0321); cycle();
    // R2/R10: all requesters contend; losers change nothing
    for (int r = 0; r < 6; r++) begin
      set_req(0, LL, 8'd12, 8'd0, '0);
      set_req(1, ST, 8'd12, 8'd0, 32'(r));
      set_req(2, SC, 8'd12, 8'd0, 32'h0000_0E00);
      set_req(3, LD, 8'd12, 8'd0, '0);
      cycle();
    end
    // mixed random traffic on a small address set
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(1, 0) == 1)
          set_req(i, 2'($urandom_range(3, 0)), AW'($urandom_range(3, 0)),
                  ($urandom_range(15, 0) == 0) ? AW'(256 - 2) : AW'(0), $urandom);
      end
      cycle();
    end
    cycle();
    cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule